// File: doc/BRIEF.md
# Parallel Transposed FIR Filter

This block is a single-rate FIR filter for sample streams that run faster than the clock. Every clock it can take a vector of `SSR` signed fixed-point samples and, after a fixed delay, it returns a vector of `SSR` filtered samples. The coefficients are fixed when the design is built. A parameter chooses a non-symmetric, even-symmetric or odd-symmetric coefficient set. The input, coefficient and output fixed-point formats are also parameters.

The filter is split into one transposed sub-filter for each pair of output lane and input lane. Each input sample is sent to all the multipliers of its sub-filters at once. Partial sums then move one registered multiply-add per step along a chain that is only about `TAPS/SSR` stages long. Because of this, the path between registers never gets longer as the filter gets longer. `SSR` must be a power of two, and any other value stops elaboration. A registered adder tree combines the `SSR` partial results of each output lane. The sum is then rounded, saturated and delayed so that the total latency is always `3*SSR+2` clocks.

Top module: `fir_ssr_transposed`

## Requirements
- R1: Lane k of `in_data` (bits `k*IN_W +: IN_W`) holds stream sample n*SSR+k, where lane 0 is the oldest. `out_data` uses the same order, with lane j in bits `j*OUT_W +: OUT_W`.
- R2: Tap i of TAPS uses b(i) = (((37*i + 11) mod 97) - 48) * 2000, as a signed integer coefficient with COEF_FRAC fraction bits. The `SYM` parameter selects the coefficient set. Mode 0 uses h[i] = b(i). Mode 1 (even) uses h[i] = b(min(i, TAPS-1-i)). Mode 2 (odd) uses h[i] = b(i) when i < TAPS-1-i, -b(TAPS-1-i) when i > TAPS-1-i, and 0 at the centre.
- R3: Each output equals the direct-form sum y[m] = sum over t of h[t]*x[m-t]. The sum is taken at full precision with IN_FRAC+COEF_FRAC fraction bits. It is then rounded half-up to OUT_FRAC fraction bits by adding 2^(shift-1) and shifting right arithmetically.
- R4: A rounded result above 2^(OUT_W-1)-1 is output as that maximum. A rounded result below -2^(OUT_W-1) is output as that minimum.
- R5: `out_valid` is high in cycle c+3*SSR+2 exactly when `in_valid` was high in cycle c. The bench samples it one clock cycle at a time.
- R6: The stream consists only of vectors accepted with `in_valid` high. Data presented while `in_valid` is low has no effect on any later output.
- R7: While `rst_n` is low at a clock edge, the output registers clear, `out_valid` drops and all filter history returns to zero. The first outputs after reset therefore see zero-valued past samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Marks `in_data` as a new input vector |
| in_data | input | SSR*IN_W | SSR signed input samples, lane 0 the oldest |
| out_valid | output | 1 | Marks `out_data` as a filtered vector |
| out_data | output | SSR*OUT_W | SSR signed, rounded and saturated output samples |

## Verification
In one cycle a vector can both saturate and sit behind a gap in `in_valid`. A reset can also land on a cycle that still has vectors in flight. The bench provokes both cases. It sends sign-matched full-scale inputs with idle cycles of garbage data between vectors, and it pulls the reset while several vectors are still in the pipeline. It judges every output against a direct-form model that it keeps itself. That model stores only the accepted samples and is cleared at each reset. The bench also checks that each result arrives on the exact cycle its latency predicts.

// File: rtl/fir_pkg.sv
// Shared definitions for the parallel transposed FIR.
// Assumes: coefficient values fit the coefficient width chosen by the user.
package fir_pkg;

    // Coefficient symmetry selector
    typedef enum logic [1:0] {
        SYM_NONE = 2'd0,
        SYM_EVEN = 2'd1,
        SYM_ODD  = 2'd2
    } fir_sym_e;

    // Prototype tap value before symmetry is applied
    function automatic int proto_tap(input int i);
        return (((i * 37 + 11) % 97) - 48) * 2000;
    endfunction

    // Coefficient of tap i for the selected symmetry
    function automatic int tap_coef(input int i, input int taps, input fir_sym_e sym);
        int m;
        m = taps - 1 - i;
        case (sym)
            SYM_EVEN: return proto_tap((i < m) ? i : m);
            SYM_ODD: begin
                if (i < m)      return proto_tap(i);
                else if (i > m) return -proto_tap(m);
                else            return 0;
            end
            default: return proto_tap(i);
        endcase
    endfunction

    // True when v is a positive power of two
    function automatic bit is_pow2(input int v);
        return (v > 0) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/fir_tap_chain.sv
// One transposed sub-filter: input lane IN_LANE feeding output lane OUT_LANE.
// Stage q holds tap j-k+q*SSR when that index is in range; otherwise the stage
// only forwards the partial sum. Every stage is one multiply-add into a register.
// Assumes: en_i is high exactly when x_i carries a new accepted sample.
module fir_tap_chain #(
    parameter int IN_W     = 16,
    parameter int COEF_W   = 18,
    parameter int ACC_W    = 39,
    parameter int TAPS     = 16,
    parameter int SSR      = 4,
    parameter int OUT_LANE = 0,
    parameter int IN_LANE  = 0,
    parameter fir_pkg::fir_sym_e SYM = fir_pkg::SYM_NONE
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en_i,
    input  logic signed [IN_W-1:0]  x_i,
    output logic signed [ACC_W-1:0] sum_o
);
    localparam int QN = (TAPS + SSR - 2) / SSR + 1;

    logic signed [ACC_W-1:0] stg_w [QN];

    for (genvar q = 0; q < QN; q++) begin : g_stage
        localparam int T = OUT_LANE - IN_LANE + q * SSR;
        logic signed [ACC_W-1:0] carry;
        logic signed [ACC_W-1:0] acc_q;

        if (q == QN - 1) begin : g_top
            assign carry = '0;
        end else begin : g_mid
            assign carry = stg_w[q+1];
        end

        if (T >= 0 && T < TAPS) begin : g_mac
            localparam logic signed [COEF_W-1:0] H =
                COEF_W'(fir_pkg::tap_coef(T, TAPS, SYM));
            logic signed [ACC_W-1:0] prod;
            assign prod = ACC_W'(x_i) * ACC_W'(H);
            // Stage register: add this tap's product to the partial sum
            always_ff @(posedge clk) begin
                if (!rst_n)    acc_q <= '0;
                else if (en_i) acc_q <= prod + carry;
            end
        end else begin : g_pass
            // Stage register: forward the partial sum without a tap
            always_ff @(posedge clk) begin
                if (!rst_n)    acc_q <= '0;
                else if (en_i) acc_q <= carry;
            end
        end

        assign stg_w[q] = acc_q;
    end

    assign sum_o = stg_w[0];

    // R6
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(sum_o));

endmodule

// File: rtl/fir_lane_sum.sv
// Registered binary adder tree that sums N partial results of one output lane.
// Assumes: N is a power of two and ACC_W already holds the full result range.
module fir_lane_sum #(
    parameter int ACC_W = 39,
    parameter int N     = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N*ACC_W-1:0]      terms_i,
    output logic signed [ACC_W-1:0] sum_o
);
    localparam int LVL = $clog2(N);

    for (genvar l = 0; l <= LVL; l++) begin : g_lvl
        localparam int CNT = N >> l;
        logic [CNT*ACC_W-1:0] v;
        if (l == 0) begin : g_leaf
            assign v = terms_i;
        end else begin : g_node
            // Tree level: add neighbouring pairs from the level below
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    v <= '0;
                end else begin
                    for (int i = 0; i < CNT; i++) begin
                        v[i*ACC_W +: ACC_W] <= g_lvl[l-1].v[2*i*ACC_W +: ACC_W]
                                             + g_lvl[l-1].v[(2*i+1)*ACC_W +: ACC_W];
                    end
                end
            end
        end
    end

    assign sum_o = g_lvl[LVL].v[ACC_W-1:0];

endmodule

// File: rtl/fir_out_stage.sv
// Rounds a full-precision sum half-up, saturates it to OUT_W bits, then delays
// it by PAD registers so the block latency does not depend on the tree depth.
// Assumes: SHIFT >= 1.
module fir_out_stage #(
    parameter int ACC_W = 39,
    parameter int OUT_W = 18,
    parameter int SHIFT = 16,
    parameter int PAD   = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [ACC_W-1:0] acc_i,
    output logic [OUT_W-1:0]        res_o
);
    localparam logic signed [ACC_W:0] HALF   = (ACC_W+1)'(1) <<< (SHIFT - 1);
    localparam logic signed [ACC_W:0] SAT_HI = (ACC_W+1)'((64'sd1 <<< (OUT_W - 1)) - 1);
    localparam logic signed [ACC_W:0] SAT_LO = -((ACC_W+1)'(64'sd1 <<< (OUT_W - 1)));
    localparam logic signed [ACC_W:0] TH_HI  = SAT_HI <<< SHIFT;
    localparam logic signed [ACC_W:0] TH_LO  = SAT_LO <<< SHIFT;
    localparam logic [OUT_W-1:0]      O_MAX  = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0]      O_MIN  = {1'b1, {(OUT_W-1){1'b0}}};

    logic signed [ACC_W:0] acc_x;
    logic signed [ACC_W:0] biased;
    logic signed [ACC_W:0] scaled;
    logic [OUT_W-1:0]      sat_c;
    logic [OUT_W-1:0]      rnd_q;

    assign acc_x  = acc_i;
    assign biased = acc_x + HALF;
    assign scaled = biased >>> SHIFT;

    // Clamp the rounded value into the output range
    always_comb begin
        if (scaled > SAT_HI)      sat_c = O_MAX;
        else if (scaled < SAT_LO) sat_c = O_MIN;
        else                      sat_c = scaled[OUT_W-1:0];
    end

    // Rounding register
    always_ff @(posedge clk) begin
        if (!rst_n) rnd_q <= '0;
        else        rnd_q <= sat_c;
    end

    if (PAD > 0) begin : g_pad
        logic [OUT_W-1:0] dly_q [PAD];
        // Alignment delay line
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < PAD; i++) dly_q[i] <= '0;
            end else begin
                dly_q[0] <= rnd_q;
                for (int i = 1; i < PAD; i++) dly_q[i] <= dly_q[i-1];
            end
        end
        assign res_o = dly_q[PAD-1];
    end else begin : g_nopad
        assign res_o = rnd_q;
    end

    // R4
    sat_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_x > TH_HI) |=> (rnd_q == O_MAX));
    // R4
    sat_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_x < TH_LO) |=> (rnd_q == O_MIN));

endmodule

// File: rtl/fir_ssr_transposed.sv
// Parallel single-rate FIR: SSR samples in and SSR samples out per clock.
// There is one transposed chain per (output lane, input lane) pair, an adder
// tree per output lane, and rounding plus alignment to a latency of 3*SSR+2.
// Assumes: SSR is a power of two and the coefficient set is fixed when built.
module fir_ssr_transposed #(
    parameter int SSR       = 4,
    parameter int TAPS      = 16,
    parameter int IN_W      = 16,
    parameter int IN_FRAC   = 15,
    parameter int COEF_W    = 18,
    parameter int COEF_FRAC = 17,
    parameter int OUT_W     = 18,
    parameter int OUT_FRAC  = 16,
    parameter fir_pkg::fir_sym_e SYM = fir_pkg::SYM_NONE
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [SSR*IN_W-1:0]    in_data,
    output logic                   out_valid,
    output logic [SSR*OUT_W-1:0]   out_data
);
    localparam int ACC_W = IN_W + COEF_W + $clog2(TAPS) + 1;
    localparam int SHIFT = IN_FRAC + COEF_FRAC - OUT_FRAC;
    localparam int LAT   = 3 * SSR + 2;
    localparam int LVL   = $clog2(SSR);
    localparam int PAD   = LAT - 3 - LVL;
    localparam int PW    = $clog2(LAT + 1) + 1;

    if (!fir_pkg::is_pow2(SSR)) begin : g_bad_ssr
        $error("SSR must be a power of two");
    end
    if (SHIFT < 1) begin : g_bad_shift
        $error("output format must drop at least one fraction bit");
    end

    logic [SSR*IN_W-1:0] x_q;
    logic [LAT-1:0]      vpipe_q;

    // Input register: capture accepted vectors only
    always_ff @(posedge clk) begin
        if (!rst_n)        x_q <= '0;
        else if (in_valid) x_q <= in_data;
    end

    // Valid shift register matching the data latency
    always_ff @(posedge clk) begin
        if (!rst_n) vpipe_q <= '0;
        else        vpipe_q <= {vpipe_q[LAT-2:0], in_valid};
    end

    assign out_valid = vpipe_q[LAT-1];

    for (genvar j = 0; j < SSR; j++) begin : g_out
        logic [SSR*ACC_W-1:0]    terms;
        logic signed [ACC_W-1:0] lane_sum;

        for (genvar k = 0; k < SSR; k++) begin : g_in
            logic signed [ACC_W-1:0] part;
            fir_tap_chain #(
                .IN_W(IN_W), .COEF_W(COEF_W), .ACC_W(ACC_W), .TAPS(TAPS),
                .SSR(SSR), .OUT_LANE(j), .IN_LANE(k), .SYM(SYM)
            ) u_chain (
                .clk   (clk),
                .rst_n (rst_n),
                .en_i  (vpipe_q[0]),
                .x_i   (x_q[k*IN_W +: IN_W]),
                .sum_o (part)
            );
            assign terms[k*ACC_W +: ACC_W] = part;
        end

        fir_lane_sum #(.ACC_W(ACC_W), .N(SSR)) u_sum (
            .clk     (clk),
            .rst_n   (rst_n),
            .terms_i (terms),
            .sum_o   (lane_sum)
        );

        fir_out_stage #(.ACC_W(ACC_W), .OUT_W(OUT_W), .SHIFT(SHIFT), .PAD(PAD)) u_out (
            .clk   (clk),
            .rst_n (rst_n),
            .acc_i (lane_sum),
            .res_o (out_data[j*OUT_W +: OUT_W])
        );
    end

    // Count of vectors accepted but not yet delivered (checking only)
    logic [PW-1:0] pend_q;
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_q + PW'(in_valid) - PW'(out_valid);
    end

    // R5
    valid_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (pend_q != '0));
    // R5
    pend_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q <= PW'(LAT));
    // R7
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_data == '0));

endmodule

// File: tb/fir_ssr_transposed_test.sv
module fir_ssr_transposed_test;
    localparam int SSR   = 4;
    localparam int TAPS  = 16;
    localparam int IN_W  = 16;
    localparam int OUT_W = 18;
    localparam int LAT   = 3 * SSR + 2;
    localparam int VW    = SSR * OUT_W;
    localparam longint OMAX = (64'sd1 <<< (OUT_W - 1)) - 1;
    localparam longint OMIN = -(64'sd1 <<< (OUT_W - 1));

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [SSR*IN_W-1:0] in_data = '0;
    logic ov0, ov1, ov2;
    logic [VW-1:0] od0, od1, od2;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    int hist[$];
    logic [VW-1:0] q_e0[$], q_e1[$], q_e2[$];
    int q_due[$];
    string q_req[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    fir_ssr_transposed uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(ov0), .out_data(od0));
    fir_ssr_transposed #(.SYM(fir_pkg::SYM_EVEN)) uut_even (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(ov1), .out_data(od1));
    fir_ssr_transposed #(.SYM(fir_pkg::SYM_ODD)) uut_odd (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(ov2), .out_data(od2));

    // R2 coefficient definition, written from the requirement
    function automatic longint ref_coef(input int mode, input int i);
        int mir;
        int idx;
        mir = TAPS - 1 - i;
        if (mode == 1) idx = (i < mir) ? i : mir;
        else           idx = i;
        if (mode == 2 && i == mir) return 0;
        if (mode == 2 && i > mir)  return -((((37 * mir + 11) % 97) - 48) * 2000);
        return (((37 * idx + 11) % 97) - 48) * 2000;
    endfunction

    // R3/R4 direct-form model with round half-up and saturation
    function automatic longint model_out(input int mode, input int idx);
        longint acc;
        longint r;
        acc = 0;
        for (int t = 0; t < TAPS; t++)
            if (idx - t >= 0) acc += ref_coef(mode, t) * longint'(hist[idx - t]);
        r = (acc + 64'sd32768) >>> 16;
        if (r > OMAX) r = OMAX;
        if (r < OMIN) r = OMIN;
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [VW-1:0] got, input logic [VW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s got=%h exp=%h", req, what, got, exp);
        end
    endtask

    task automatic send(input int s [SSR], input string req);
        int base;
        logic [VW-1:0] e [3];
        longint v;
        @(negedge clk);
        in_valid = 1'b1;
        for (int k = 0; k < SSR; k++) begin
            in_data[k*IN_W +: IN_W] = s[k][IN_W-1:0];
            hist.push_back(s[k]);
        end
        base = hist.size() - SSR;
        for (int m = 0; m < 3; m++) begin
            for (int j = 0; j < SSR; j++) begin
                v = model_out(m, base + j);
                e[m][j*OUT_W +: OUT_W] = v[OUT_W-1:0];
            end
        end
        q_e0.push_back(e[0]);
        q_e1.push_back(e[1]);
        q_e2.push_back(e[2]);
        q_due.push_back(cyc + LAT);
        q_req.push_back(req);
    endtask

    // R6: idle cycles carry garbage that must not reach the stream
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_data = {$urandom, $urandom};
        end
    endtask

    task automatic send_rand(input int n, input string req, input bit gaps);
        int s [SSR];
        for (int i = 0; i < n; i++) begin
            for (int k = 0; k < SSR; k++) s[k] = int'($urandom % 65536) - 32768;
            send(s, req);
            if (gaps) idle(1 + i % 3);
        end
    endtask

    task automatic reset_now(input int n);
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        q_e0.delete(); q_e1.delete(); q_e2.delete(); q_due.delete(); q_req.delete();
        hist.delete();
        repeat (n) @(negedge clk);
        // R7 outputs cleared while reset is held
        chk(!ov0 && !ov1 && !ov2, "R7", "valid in reset", VW'(ov0), '0);
        chk(od0 == '0 && od1 == '0 && od2 == '0, "R7", "data in reset", od0, '0);
        rst_n = 1'b1;
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (ov0 || ov1 || ov2)
                chk(ov0 == ov1 && ov0 == ov2, "R5", "valid agreement", VW'({ov0, ov1, ov2}), '1);
            if (ov0) begin
                if (q_due.size() == 0) begin
                    chk(1'b0, "R5", "unexpected valid", VW'(cyc), '0);
                end else begin
                    chk(cyc == q_due[0], "R5", "arrival cycle", VW'(cyc), VW'(q_due[0]));
                    chk(od0 == q_e0[0], q_req[0], "mode0 data", od0, q_e0[0]);
                    chk(od1 == q_e1[0], "R2", "even data", od1, q_e1[0]);
                    chk(od2 == q_e2[0], "R2", "odd data", od2, q_e2[0]);
                    void'(q_e0.pop_front()); void'(q_e1.pop_front()); void'(q_e2.pop_front());
                    void'(q_due.pop_front()); void'(q_req.pop_front());
                end
            end else if (q_due.size() > 0 && q_due[0] <= cyc) begin
                chk(1'b0, "R5", "missing valid", '0, VW'(q_due[0]));
                void'(q_e0.pop_front()); void'(q_e1.pop_front()); void'(q_e2.pop_front());
                void'(q_due.pop_front()); void'(q_req.pop_front());
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (!done && cyc > 20000) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL R5 watchdog got=%0d exp=finished", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int s [SSR];
        reset_now(4);

        // R1 lane ordering: single impulse in lane 2, then zeros
        s = '{0, 0, 16384, 0};
        send(s, "R1");
        s = '{0, 0, 0, 0};
        for (int i = 0; i < 5; i++) send(s, "R1");
        s = '{-32768, 0, 0, 1};
        send(s, "R1");
        idle(2);

        // R3 continuous random stream
        send_rand(40, "R3", 1'b0);

        // R6 stream with garbage on idle cycles
        send_rand(20, "R6", 1'b1);

        // R4 sign-matched full-scale inputs, positive then negative
        for (int sgn = 0; sgn < 2; sgn++) begin
            for (int b = 0; b < TAPS / SSR; b++) begin
                for (int k = 0; k < SSR; k++) begin
                    int u;
                    bit pos;
                    u = b * SSR + k;
                    pos = (ref_coef(0, TAPS - 1 - u) >= 0) ^ (sgn == 1);
                    s[k] = pos ? 32767 : -32768;
                end
                send(s, "R4");
                if (b == 1) idle(2);
            end
        end
        idle(1);

        // R7 reset with vectors in flight, then fresh history
        send_rand(3, "R7", 1'b0);
        reset_now(2);
        s = '{0, 20000, 0, 0};
        send(s, "R7");
        send_rand(8, "R7", 1'b0);
        idle(1);

        for (int i = 0; i < 200 && q_due.size() > 0; i++) @(negedge clk);
        chk(q_due.size() == 0, "R5", "queue drained", VW'(q_due.size()), '0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule